// File: doc/BRIEF.md
# Scan and Frame Acquisition Sequencer

This block decides when a converter is told to start and which input channel is addressed for each conversion. The host sets up a configuration and then pulses `arm`. Arming raises the acquire flag, loads the sample budget and puts the first channel on the address lines. From then on, every accepted trigger opens one frame.

A trigger comes either from an internal pacer or from the falling edge of an external trigger line. A frame holds one of three amounts of work:

- a single sample,
- one scan over the channel window,
- several scans back to back, with the channel address wrapping inside the frame.

Inside a frame, conversion starts are spaced by a programmable 16-bit divisor, and each start also waits for the previous end-of-conversion. The channel can be addressed in three ways: a fixed channel, automatic sequencing between a first and a last channel, or a channel number supplied by the host.

A sample counter counts end-of-conversion events. When its budget is spent, the acquire flag drops and no further frames run until the block is armed again. A trigger that arrives while a frame is still running is dropped, and a sticky flag records the loss.

Top module: `acq_seq`

## Requirements
- R1: After reset, `conv_start`, `acq`, `diff_out` and `trig_missed` are 0 and `chan` is 0.
- R2: A one-cycle `arm` pulse takes effect in the following cycle. It sets `acq` to 1, clears `trig_missed`, copies `diff_en` to `diff_out` and loads the start channel: `host_ch` in host mode, otherwise `first_ch`.
- R3: With `trig_ext_sel`=1, a trigger is a 1-to-0 transition of `ext_trig_n` seen between two clock edges. A rising transition is not a trigger. With `trig_ext_sel`=0, the pacer gives a trigger every `frame_div`+1 cycles, with the first one `frame_div`+1 cycles after `arm` takes effect. Triggers are not accepted while `acq` is 0.
- R4: `frame_kind` sets the number of conversion starts in a frame. 0 gives one start. 1 gives one scan of span starts. 2 gives span×(`scans_m1`+1) starts. Here span = last−first+1 after masking, or 1 if last < first.
- R5: With `addr_mode`=1 (sequential), each end-of-conversion moves `chan` from its current value to the next channel, and from `last_ch` back to `first_ch`. The wrap carries across scans and across frames.
- R6: With `addr_mode`=0 (fixed), `chan` stays at `first_ch`. With `addr_mode`=2 (host), `chan` takes `host_ch` at arm and at each end-of-conversion.
- R7: When `diff_out` is 1, every channel number is masked to its low three bits, so `chan` stays in 0..7.
- R8: After a start, the next start of the same frame comes at the later of two cycles: `start_div`+1 cycles after that start, or the cycle after the one following end-of-conversion.
- R9: `conv_start` is high for exactly one cycle. The first start of a frame is high in the cycle after the trigger event.
- R10: `chan` holds its value during the end-of-conversion cycle and takes its new value in the next cycle.
- R11: After `samples_m1`+1 end-of-conversion pulses, `acq` falls in the following cycle. No further start occurs until the block is armed again.
- R12: A trigger while a frame is running starts nothing extra and sets `trig_missed` to 1. The flag stays set until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle command pulse that arms acquisition |
| addr_mode | input | 2 | 0 fixed, 1 sequential, 2 host channel |
| diff_en | input | 1 | Differential mode, sampled at arm |
| first_ch | input | 4 | First channel of the scan window |
| last_ch | input | 4 | Last channel of the scan window |
| host_ch | input | 4 | Channel number supplied by the host |
| frame_kind | input | 2 | 0 one sample, 1 one scan, 2 multiple scans |
| scans_m1 | input | 4 | Scans per frame minus one (kind 2) |
| samples_m1 | input | 16 | Sample budget minus one |
| start_div | input | 16 | Start spacing divisor |
| frame_div | input | 16 | Pacer period divisor |
| trig_ext_sel | input | 1 | 1 selects the external trigger, 0 the pacer |
| ext_trig_n | input | 1 | External trigger, active on its falling edge |
| eoc | input | 1 | End-of-conversion pulse from the converter |
| chan | output | 4 | Channel address |
| diff_out | output | 1 | Single-ended (0) or differential (1) mode |
| conv_start | output | 1 | One-cycle convert-start pulse |
| acq | output | 1 | Acquire flag |
| trig_missed | output | 1 | Sticky flag: a trigger was dropped |

## Verification
If the channel state is wrong, `chan` shows the wrong value at the very next `conv_start` after the end-of-conversion that should have moved it. A broken wrap shows up one start after `last_ch`.

If the frame or sample counters are off, the number of starts per trigger changes, or `acq` falls one cycle late or not at all. The spacing timer and the trigger path show up directly in the cycle distance between starts and between the trigger and the first start. The dropped-trigger flag is observed at the port as soon as a second trigger lands inside a running frame.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  localparam int SEQ_CH_W  = 4;
  localparam int SEQ_CNT_W = 16;
  localparam int SEQ_SCN_W = 4;

  typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_SEQ = 2'd1, AM_HOST = 2'd2} addr_mode_e;
  typedef enum logic [1:0] {FK_ONE = 2'd0, FK_SCAN = 2'd1, FK_MULTI = 2'd2} frame_kind_e;

  function automatic logic [SEQ_CH_W-1:0] ch_lim(input logic [SEQ_CH_W-1:0] ch, input logic diff);
    ch_lim = diff ? {1'b0, ch[SEQ_CH_W-2:0]} : ch;
  endfunction

  function automatic logic [SEQ_CH_W-1:0] next_seq(input logic [SEQ_CH_W-1:0] cur,
                                                   input logic [SEQ_CH_W-1:0] f,
                                                   input logic [SEQ_CH_W-1:0] l);
    next_seq = (cur >= l) ? f : cur + 1'b1;
  endfunction

  function automatic logic [SEQ_CNT_W-1:0] frame_len(input logic [1:0] kind,
                                                     input logic [SEQ_CH_W-1:0] f,
                                                     input logic [SEQ_CH_W-1:0] l,
                                                     input logic [SEQ_SCN_W-1:0] scans);
    logic [SEQ_CNT_W-1:0] span;
    span = (l >= f) ? (SEQ_CNT_W'(l) - SEQ_CNT_W'(f) + SEQ_CNT_W'(1)) : SEQ_CNT_W'(1);
    case (kind)
      FK_SCAN:  frame_len = span;
      FK_MULTI: frame_len = span * (SEQ_CNT_W'(scans) + SEQ_CNT_W'(1));
      default:  frame_len = SEQ_CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (reload || !run) cnt_q <= div;
    else if (cnt_q == '0) cnt_q <= div;
    else cnt_q <= cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/acq_trig.sv
module acq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic ext_n,
  input  logic pace_tick,
  output logic trig
);
  logic ext_q;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b1;
    else ext_q <= ext_n;
  end

  assign fall = ext_q && !ext_n;
  assign trig = ext_sel ? fall : pace_tick;
endmodule

// File: rtl/acq_chan.sv
module acq_chan
  import acq_seq_pkg::*;
#(
  parameter int CH_W = SEQ_CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            adv,
  input  logic [1:0]      mode,
  input  logic            diff,
  input  logic [CH_W-1:0] first_ch,
  input  logic [CH_W-1:0] last_ch,
  input  logic [CH_W-1:0] host_ch,
  output logic [CH_W-1:0] ch
);
  logic [CH_W-1:0] f_m, l_m, h_m, nxt;

  assign f_m = ch_lim(first_ch, diff);
  assign l_m = ch_lim(last_ch, diff);
  assign h_m = ch_lim(host_ch, diff);

  always_comb begin
    case (mode)
      AM_SEQ:  nxt = next_seq(ch, f_m, l_m);
      AM_HOST: nxt = h_m;
      default: nxt = f_m;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ch <= '0;
    else if (load) ch <= (mode == AM_HOST) ? h_m : f_m;
    else if (adv) ch <= nxt;
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_seq_pkg::*;
#(
  parameter int CH_W  = SEQ_CH_W,
  parameter int CNT_W = SEQ_CNT_W,
  parameter int SCN_W = SEQ_SCN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [1:0]       addr_mode,
  input  logic             diff_en,
  input  logic [CH_W-1:0]  first_ch,
  input  logic [CH_W-1:0]  last_ch,
  input  logic [CH_W-1:0]  host_ch,
  input  logic [1:0]       frame_kind,
  input  logic [SCN_W-1:0] scans_m1,
  input  logic [CNT_W-1:0] samples_m1,
  input  logic [CNT_W-1:0] start_div,
  input  logic [CNT_W-1:0] frame_div,
  input  logic             trig_ext_sel,
  input  logic             ext_trig_n,
  input  logic             eoc,
  output logic [CH_W-1:0]  chan,
  output logic             diff_out,
  output logic             conv_start,
  output logic             acq,
  output logic             trig_missed
);
  logic             acq_q, running_q, eoc_seen_q, start_q, missed_q, diff_q;
  logic [CNT_W-1:0] rem_q, left_q, gap_q;
  logic             pace_tick, trig_evt;
  logic             accept_evt, issue_evt, adv_evt, last_eoc, frame_end;
  logic             diff_sel;
  logic [CNT_W-1:0] flen;

  acq_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(acq_q), .reload(arm),
    .div(frame_div), .tick(pace_tick)
  );

  acq_trig u_trig (
    .clk(clk), .rst_n(rst_n), .ext_sel(trig_ext_sel), .ext_n(ext_trig_n),
    .pace_tick(pace_tick), .trig(trig_evt)
  );

  assign diff_sel = arm ? diff_en : diff_q;

  acq_chan #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .load(arm), .adv(adv_evt), .mode(addr_mode),
    .diff(diff_sel), .first_ch(first_ch), .last_ch(last_ch), .host_ch(host_ch),
    .ch(chan)
  );

  assign flen       = frame_len(frame_kind, ch_lim(first_ch, diff_q),
                                ch_lim(last_ch, diff_q), scans_m1);
  assign accept_evt = trig_evt && acq_q && !running_q && !arm;
  assign issue_evt  = running_q && eoc_seen_q && (gap_q == '0) && !arm;
  assign adv_evt    = running_q && eoc && !arm;
  assign last_eoc   = adv_evt && (rem_q == '0);
  assign frame_end  = adv_evt && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_q      <= 1'b0;
      running_q  <= 1'b0;
      eoc_seen_q <= 1'b0;
      start_q    <= 1'b0;
      missed_q   <= 1'b0;
      diff_q     <= 1'b0;
      rem_q      <= '0;
      left_q     <= '0;
      gap_q      <= '0;
    end else begin
      start_q <= accept_evt || issue_evt;
      if (arm) begin
        acq_q      <= 1'b1;
        running_q  <= 1'b0;
        eoc_seen_q <= 1'b0;
        missed_q   <= 1'b0;
        diff_q     <= diff_en;
        rem_q      <= samples_m1;
        gap_q      <= '0;
      end else begin
        if (gap_q != '0) gap_q <= gap_q - 1'b1;
        if (accept_evt) begin
          running_q  <= 1'b1;
          left_q     <= flen - CNT_W'(1);
          gap_q      <= start_div;
          eoc_seen_q <= 1'b0;
        end
        if (issue_evt) begin
          eoc_seen_q <= 1'b0;
          left_q     <= left_q - 1'b1;
          gap_q      <= start_div;
        end
        if (adv_evt) begin
          rem_q <= rem_q - 1'b1;
          if (last_eoc || frame_end) running_q <= 1'b0;
          else eoc_seen_q <= 1'b1;
          if (last_eoc) acq_q <= 1'b0;
        end
        if (trig_evt && acq_q && running_q) missed_q <= 1'b1;
      end
    end
  end

  assign conv_start  = start_q;
  assign acq         = acq_q;
  assign diff_out    = diff_q;
  assign trig_missed = missed_q;
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arm,
  input logic            eoc,
  input logic            conv_start,
  input logic            acq,
  input logic            diff_out,
  input logic            trig_missed,
  input logic [CH_W-1:0] chan,
  input logic            adv_evt,
  input logic            trig_evt,
  input logic            running_q
);
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R11
  acq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acq) |-> $past(eoc));

  // R11
  start_needs_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> acq);

  // R7
  diff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diff_out |-> (chan[CH_W-1] == 1'b0));

  // R10
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_evt && !arm) |=> $stable(chan));

  // R12
  missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && acq && running_q && !arm) |=> trig_missed);

  // R2
  arm_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (acq && !trig_missed));
endmodule

bind acq_seq acq_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .eoc(eoc), .conv_start(conv_start),
  .acq(acq), .diff_out(diff_out), .trig_missed(trig_missed), .chan(chan),
  .adv_evt(adv_evt), .trig_evt(trig_evt), .running_q(running_q)
);

// File: tb/acq_seq_test.sv
`timescale 1ns/1ps
module acq_seq_test;
  logic        clk = 0, rst_n = 0, arm = 0, diff_en = 0, trig_ext_sel = 1, ext_trig_n = 1, eoc = 0;
  logic [1:0]  addr_mode = 1, frame_kind = 1;
  logic [3:0]  first_ch = 0, last_ch = 0, host_ch = 0, scans_m1 = 0;
  logic [15:0] samples_m1 = 0, start_div = 0, frame_div = 0;
  logic [3:0]  chan;
  logic        diff_out, conv_start, acq, trig_missed;

  acq_seq uut (.*);

  always #10 clk = ~clk;

  int cyc = 0, nchk = 0, nfail = 0, n = 0;
  int st_cyc[0:63];
  int st_ch[0:63];
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [1:0] mode; logic diff; logic [3:0] first; logic [3:0] last; logic [3:0] host;
    logic [1:0] kind; logic [3:0] scans; logic [15:0] smp; logic [15:0] div;
    logic [15:0] exp_starts; logic [15:0] exp_gap;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{2'd1, 1'b0, 4'd2,  4'd5,  4'd0,  2'd1, 4'd0, 16'd99,  16'd5,  16'd4,  16'd6},
    '{2'd1, 1'b0, 4'd14, 4'd15, 4'd0,  2'd2, 4'd2, 16'd99,  16'd0,  16'd6,  16'd5},
    '{2'd0, 1'b0, 4'd9,  4'd11, 4'd3,  2'd2, 4'd1, 16'd99,  16'd20, 16'd6,  16'd21},
    '{2'd1, 1'b1, 4'd5,  4'd15, 4'd0,  2'd1, 4'd0, 16'd99,  16'd5,  16'd3,  16'd6},
    '{2'd2, 1'b0, 4'd1,  4'd4,  4'd10, 2'd0, 4'd0, 16'd99,  16'd5,  16'd1,  16'd6},
    '{2'd1, 1'b0, 4'd0,  4'd3,  4'd0,  2'd2, 4'd3, 16'd9,   16'd5,  16'd10, 16'd6}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // converter model: eoc three cycles after a start
  initial forever begin
    @(negedge clk);
    if (conv_start) begin
      repeat (3) @(negedge clk);
      eoc = 1;
      @(negedge clk);
      eoc = 0;
    end
  end

  // monitor, sampled just after the falling edge
  initial forever begin
    @(negedge clk); #1;
    if (conv_start && n < 64) begin st_cyc[n] = cyc; st_ch[n] = chan; n++; end
    if (eoc && n > 0) chk(chan == st_ch[n-1][3:0], "R10 chan held in eoc cycle", chan, st_ch[n-1]);
  end

  function automatic int model_ch(vec_t v, int k);
    int f, l, h;
    f = v.diff ? (v.first & 7) : v.first;
    l = v.diff ? (v.last & 7) : v.last;
    h = v.diff ? (v.host & 7) : v.host;
    if (v.mode == 2'd2) return h;
    if (v.mode == 2'd0) return f;
    return f + (k % (l - f + 1));
  endfunction

  task automatic do_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0; n = 0;
  endtask

  task automatic ext_pulse(output int tc);
    @(negedge clk); ext_trig_n = 0; tc = cyc;
    @(negedge clk); ext_trig_n = 1;
  endtask

  int tc, acyc;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset values
    chk(conv_start == 0 && acq == 0 && trig_missed == 0 && diff_out == 0, "R1 reset flags", {conv_start, acq, trig_missed, diff_out}, 0);
    chk(chan == 0, "R1 reset chan", chan, 0);

    // R3 no trigger accepted while acq low
    n = 0;
    ext_pulse(tc);
    repeat (20) @(negedge clk);
    chk(n == 0, "R3 trigger ignored before arm", n, 0);

    for (int i = 0; i < 6; i++) begin
      vec_t v;
      int tag_acq;
      v = VEC[i];
      @(negedge clk);
      addr_mode = v.mode; diff_en = v.diff; first_ch = v.first; last_ch = v.last;
      host_ch = v.host; frame_kind = v.kind; scans_m1 = v.scans; samples_m1 = v.smp;
      start_div = v.div; trig_ext_sel = 1;
      do_arm();
      #1;
      chk(acq == 1, "R2 acq after arm", acq, 1);
      chk(chan == 4'(model_ch(v, 0)), "R2 start channel", chan, model_ch(v, 0));
      repeat (3) @(negedge clk);
      ext_pulse(tc);
      repeat (400) @(negedge clk);
      chk(n == int'(v.exp_starts), "R4 starts per frame", n, v.exp_starts);
      chk(st_cyc[0] == tc + 1, "R9 first start after trigger", st_cyc[0], tc + 1);
      for (int k = 1; k < n; k++)
        chk(st_cyc[k] - st_cyc[k-1] == int'(v.exp_gap), "R8 start spacing", st_cyc[k] - st_cyc[k-1], v.exp_gap);
      for (int k = 0; k < n; k++)
        chk(st_ch[k] == model_ch(v, k), v.mode == 2'd1 ? "R5 sequential chan" : "R6 fixed/host chan", st_ch[k], model_ch(v, k));
      tag_acq = (int'(v.exp_starts) < int'(v.smp) + 1) ? 1 : 0;
      chk(acq == tag_acq, "R11 acq after frame", acq, tag_acq);
      chk(diff_out == v.diff, "R7 diff mode out", diff_out, v.diff);
      chk(trig_missed == 0, "R12 no missed trigger", trig_missed, 0);
    end

    // R11 acq cleared: further trigger starts nothing
    n = 0;
    ext_pulse(tc);
    repeat (40) @(negedge clk);
    chk(n == 0, "R11 no start after budget spent", n, 0);

    // R12 trigger during running frame
    @(negedge clk);
    addr_mode = 1; diff_en = 0; first_ch = 0; last_ch = 15; frame_kind = 1;
    samples_m1 = 999; start_div = 5;
    do_arm();
    repeat (2) @(negedge clk);
    ext_pulse(tc);
    repeat (10) @(negedge clk);
    ext_pulse(tc);
    repeat (200) @(negedge clk);
    chk(n == 16, "R12 extra trigger starts nothing", n, 16);
    chk(trig_missed == 1, "R12 missed flag set", trig_missed, 1);
    for (int k = 0; k < n; k++)
      chk(st_ch[k] == k, "R5 full window sweep", st_ch[k], k);
    first_ch = 3;
    do_arm();
    #1;
    chk(trig_missed == 0, "R2 arm clears missed flag", trig_missed, 0);
    chk(chan == 3, "R2 arm loads first channel", chan, 3);

    // R3 internal pacer
    @(negedge clk);
    trig_ext_sel = 0; frame_div = 40; frame_kind = 0; first_ch = 0; last_ch = 3;
    @(negedge clk); arm = 1; acyc = cyc;
    @(negedge clk); arm = 0; n = 0;
    repeat (150) @(negedge clk);
    chk(st_cyc[0] == acyc + 42, "R3 first pacer trigger", st_cyc[0], acyc + 42);
    chk(st_cyc[1] - st_cyc[0] == 41, "R3 pacer period", st_cyc[1] - st_cyc[0], 41);
    chk(st_ch[1] == 1 && st_ch[2] == 2, "R5 wrap across frames", st_ch[2], 2);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #4000000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule